// File: doc/BRIEF.md
# Phase-Frequency Detector with Charge-Pump Drive Control

This block compares two synchronous pulse trains, one taken from the divided reference and one from the divided oscillator. It turns their rising edges into the control signals of a charge pump. The `src_up` signal tells the pump to source current and `snk_dn` tells it to sink current. The `drive_en` signal tells the output stage to drive; when `drive_en` is low the pump output floats at high impedance. A configuration bit swaps the roles of source and sink, so loops with an inverting oscillator can use the block.

A standby input holds the output at high impedance and ignores the pulse inputs. A current-magnitude code passes through to the pump. The block loads a new code only between comparisons, so the code never changes in the middle of a correction pulse. A lock indicator reports when the correction pulses have stayed narrow for a run of comparisons.

The detector keeps two edge flags. Each flag is set by the rising edge of its own input. Once both flags are set, a short delay counter runs, and when it expires both flags clear together. The width of a correction pulse therefore follows the timing error between the two edges. Every flag is registered on `clk`, and the pulse inputs must already be synchronous to that clock.

Top module: `pfd_tristate_ctrl`

## Requirements
- R1: When the rising edge of `ref_pulse` comes k cycles before the rising edge of `vco_pulse` (k ≥ 1), and `invert_pol`=0, `src_up` is high for k+RST_DLY consecutive cycles, starting in the cycle after the reference edge is sampled. `snk_dn` is high for RST_DLY cycles (default RST_DLY=2). Only a rising edge counts: a pulse input held high starts one comparison.
- R2: When the rising edge of `vco_pulse` comes k cycles before that of `ref_pulse`, and `invert_pol`=0, `snk_dn` is high for k+RST_DLY cycles and `src_up` is high for RST_DLY cycles.
- R3: When both rising edges are sampled in the same cycle, `src_up` and `snk_dn` are each high for RST_DLY cycles only. With no edges, both stay low and the output is at high impedance (`drive_en`=0).
- R4: With `invert_pol`=1, the cycle counts of `src_up` and `snk_dn` from R1 to R3 are exchanged.
- R5: While `standby`=1, `src_up`, `snk_dn` and `drive_en` are low whatever the pulse inputs do, and `locked` is low from the next cycle on.
- R6: `drive_en` is high in exactly the cycles in which `src_up` or `snk_dn` is high.
- R7: The width of a comparison is the number of cycles in which exactly one edge flag is set. `locked` rises at the end of the LOCK_CNT-th consecutive comparison (default 16) whose width is below LOCK_THR (default 4). It falls at the end of the first comparison whose width is LOCK_THR or more.
- R8: `ilevel_out` takes the value of `ilevel_in` on each clock edge at which no comparison is in progress. While `src_up` or `snk_dn` is high, it holds its value.
- R9: After reset, `src_up`, `snk_dn`, `drive_en` and `locked` are low and `ilevel_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_pulse | input | 1 | Divided reference, synchronous to clk |
| vco_pulse | input | 1 | Divided oscillator, synchronous to clk |
| invert_pol | input | 1 | Exchanges the source and sink outputs when 1 |
| standby | input | 1 | Forces high impedance and clears detector state |
| ilevel_in | input | CUR_W | Requested charge-pump current code |
| src_up | output | 1 | Charge pump sources current |
| snk_dn | output | 1 | Charge pump sinks current |
| drive_en | output | 1 | Output driven; low means high impedance |
| ilevel_out | output | CUR_W | Current code, stable during a comparison |
| locked | output | 1 | Lock indicator |

## Verification
On every cycle the assertions check four things: standby silences all three drive outputs, standby clears the lock flag by the next cycle, the current code holds while a correction pulse is active, and the lock flag only rises at the end of a comparison. The pulse widths for a given edge skew, the exchange of source and sink under inversion, and the exact comparison at which lock is gained or lost are shown only by the bench's directed scenarios. Those scenarios count output cycles over whole comparisons.

// File: rtl/pfd_tristate_ctrl.sv
module pfd_tristate_ctrl #(
  parameter int CUR_W    = 3,
  parameter int RST_DLY  = 2,
  parameter int LOCK_THR = 4,
  parameter int LOCK_CNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_pulse,
  input  logic             vco_pulse,
  input  logic             invert_pol,
  input  logic             standby,
  input  logic [CUR_W-1:0] ilevel_in,
  output logic             src_up,
  output logic             snk_dn,
  output logic             drive_en,
  output logic [CUR_W-1:0] ilevel_out,
  output logic             locked
);
  localparam int DLY_W  = $clog2(RST_DLY + 1);
  localparam int WID_W  = $clog2(LOCK_THR + 1);
  localparam int GOOD_W = $clog2(LOCK_CNT + 1);

  logic              ref_q, vco_q;
  logic              up_f, dn_f;
  logic [DLY_W-1:0]  dly;
  logic [WID_W-1:0]  wid;
  logic [GOOD_W-1:0] good;
  logic              lock_q;
  logic [CUR_W-1:0]  cur_q;

  logic ref_rise, vco_rise, both, clr, width_ok, last_good;
  assign ref_rise  = ref_pulse & ~ref_q;
  assign vco_rise  = vco_pulse & ~vco_q;
  assign both      = up_f & dn_f;
  assign clr       = both && (dly == DLY_W'(RST_DLY - 1));
  assign width_ok  = wid < WID_W'(LOCK_THR);
  assign last_good = good == GOOD_W'(LOCK_CNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= 1'b0;
      vco_q  <= 1'b0;
      up_f   <= 1'b0;
      dn_f   <= 1'b0;
      dly    <= '0;
      wid    <= '0;
      good   <= '0;
      lock_q <= 1'b0;
      cur_q  <= '0;
    end else begin
      ref_q <= ref_pulse;
      vco_q <= vco_pulse;
      if (standby) begin
        up_f   <= 1'b0;
        dn_f   <= 1'b0;
        dly    <= '0;
        wid    <= '0;
        good   <= '0;
        lock_q <= 1'b0;
      end else begin
        up_f <= (up_f & ~clr) | ref_rise;
        dn_f <= (dn_f & ~clr) | vco_rise;
        dly  <= (both && !clr) ? dly + 1'b1 : '0;
        if (clr)
          wid <= '0;
        else if ((up_f ^ dn_f) && wid != WID_W'(LOCK_THR))
          wid <= wid + 1'b1;
        if (clr) begin
          if (width_ok) begin
            good <= last_good ? good : good + 1'b1;
            if (last_good) lock_q <= 1'b1;
          end else begin
            good   <= '0;
            lock_q <= 1'b0;
          end
        end
      end
      if (!up_f && !dn_f) cur_q <= ilevel_in;
    end
  end

  assign src_up     = ~standby & (invert_pol ? dn_f : up_f);
  assign snk_dn     = ~standby & (invert_pol ? up_f : dn_f);
  assign drive_en   = src_up | snk_dn;
  assign ilevel_out = cur_q;
  assign locked     = lock_q;
endmodule

// File: rtl/pfd_tristate_ctrl_chk.sv
module pfd_tristate_ctrl_chk #(
  parameter int CUR_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             standby,
  input logic             src_up,
  input logic             snk_dn,
  input logic             drive_en,
  input logic [CUR_W-1:0] ilevel_out,
  input logic             locked
);
  p_standby_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> (!src_up && !snk_dn && !drive_en));

  p_standby_unlock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !locked);

  p_code_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_up || snk_dn) |=> $stable(ilevel_out));

  p_lock_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(src_up && snk_dn));
endmodule

bind pfd_tristate_ctrl pfd_tristate_ctrl_chk #(.CUR_W(CUR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .standby(standby), .src_up(src_up),
  .snk_dn(snk_dn), .drive_en(drive_en), .ilevel_out(ilevel_out),
  .locked(locked)
);

// File: tb/pfd_tristate_ctrl_tb.sv
module pfd_tristate_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CUR_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_pulse = 1'b0, vco_pulse = 1'b0, invert_pol = 1'b0, standby = 1'b0;
  logic [CUR_W-1:0] ilevel_in = '0;
  logic src_up, snk_dn, drive_en, locked;
  logic [CUR_W-1:0] ilevel_out;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pfd_tristate_ctrl #(.CUR_W(CUR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .vco_pulse(vco_pulse),
    .invert_pol(invert_pol), .standby(standby), .ilevel_in(ilevel_in),
    .src_up(src_up), .snk_dn(snk_dn), .drive_en(drive_en),
    .ilevel_out(ilevel_out), .locked(locked)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one comparison: edges at window cycles rd and vd; counts high cycles
  task automatic compare(input int rd, input int vd, output int n_up, output int n_dn,
                         output int n_en, output int n_mis);
    n_up = 0; n_dn = 0; n_en = 0; n_mis = 0;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      n_up += int'(src_up);
      n_dn += int'(snk_dn);
      n_en += int'(drive_en);
      if (drive_en != (src_up | snk_dn)) n_mis++;
      ref_pulse = (c == rd);
      vco_pulse = (c == vd);
    end
    ref_pulse = 1'b0;
    vco_pulse = 1'b0;
  endtask

  task automatic t_reset;
    check("R9", "src_up", int'(src_up), 0);
    check("R9", "snk_dn", int'(snk_dn), 0);
    check("R9", "drive_en", int'(drive_en), 0);
    check("R9", "locked", int'(locked), 0);
    check("R9", "ilevel_out", int'(ilevel_out), 0);
  endtask

  task automatic t_ref_lead;
    int u, d, e, m;
    compare(0, 5, u, d, e, m);
    check("R1", "up cycles k=5", u, 7);
    check("R1", "dn cycles k=5", d, 2);
    check("R6", "en cycles", e, 7);
    check("R6", "en mismatch", m, 0);
    // held-high reference level starts only one comparison
    @(negedge clk); ref_pulse = 1'b1;
    repeat (3) @(negedge clk);
    vco_pulse = 1'b1;
    @(negedge clk); vco_pulse = 1'b0;
    repeat (10) @(negedge clk);
    check("R1", "level held, src_up idle", int'(src_up), 0);
    ref_pulse = 1'b0;
  endtask

  task automatic t_vco_lead;
    int u, d, e, m;
    compare(3, 0, u, d, e, m);
    check("R2", "up cycles k=3", u, 2);
    check("R2", "dn cycles k=3", d, 5);
    check("R6", "en mismatch", m, 0);
  endtask

  task automatic t_equal;
    int u, d, e, m;
    compare(2, 2, u, d, e, m);
    check("R3", "up cycles", u, 2);
    check("R3", "dn cycles", d, 2);
    compare(99, 99, u, d, e, m);
    check("R3", "idle en cycles", e, 0);
  endtask

  task automatic t_invert;
    int u, d, e, m;
    invert_pol = 1'b1;
    compare(0, 3, u, d, e, m);
    check("R4", "inverted up cycles", u, 2);
    check("R4", "inverted dn cycles", d, 5);
    compare(4, 0, u, d, e, m);
    check("R4", "inverted vco-lead up", u, 6);
    check("R4", "inverted vco-lead dn", d, 2);
    invert_pol = 1'b0;
  endtask

  task automatic t_lock;
    int u, d, e, m;
    compare(0, 6, u, d, e, m);
    check("R7", "locked after wide", int'(locked), 0);
    for (int i = 0; i < 15; i++) compare(0, 1, u, d, e, m);
    check("R7", "locked after 15", int'(locked), 0);
    compare(1, 0, u, d, e, m);
    check("R7", "locked after 16", int'(locked), 1);
    compare(0, 3, u, d, e, m);
    check("R7", "width 3 keeps lock", int'(locked), 1);
    compare(0, 4, u, d, e, m);
    check("R7", "width 4 drops lock", int'(locked), 0);
  endtask

  task automatic t_standby;
    int u, d, e, m;
    for (int i = 0; i < 16; i++) compare(0, 0, u, d, e, m);
    check("R7", "locked before standby", int'(locked), 1);
    @(negedge clk); standby = 1'b1;
    compare(0, 3, u, d, e, m);
    check("R5", "standby up", u, 0);
    check("R5", "standby dn", d, 0);
    check("R5", "standby en", e, 0);
    check("R5", "standby locked", int'(locked), 0);
    @(negedge clk); standby = 1'b0;
    compare(0, 2, u, d, e, m);
    check("R5", "after standby up", u, 4);
    check("R5", "after standby dn", d, 2);
  endtask

  task automatic t_current;
    @(negedge clk); ilevel_in = 3'd5;
    @(negedge clk);
    check("R8", "idle load", int'(ilevel_out), 5);
    ref_pulse = 1'b1;
    @(negedge clk); ref_pulse = 1'b0; ilevel_in = 3'd6;
    repeat (3) @(negedge clk);
    check("R8", "held mid-pulse", int'(ilevel_out), 5);
    vco_pulse = 1'b1;
    @(negedge clk); vco_pulse = 1'b0;
    check("R8", "held in reset delay", int'(ilevel_out), 5);
    repeat (5) @(negedge clk);
    check("R8", "loaded after pulse", int'(ilevel_out), 6);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_ref_lead();
    t_vco_lead();
    t_equal();
    t_invert();
    t_lock();
    t_standby();
    t_current();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule